// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is a synchronous behavioural model of the memory side of a by-one dynamic RAM. It samples the active-low row strobe, column strobe and write-enable on every clock. It classifies each memory cycle from the order in which those strobes fall. The classes are read, early write, read-modify-write, strobe-ordered refresh driven by an internal row counter, refresh of an explicit row, and test entry. A small register array stands in for the storage cells.

A one-bit mode flag selects normal or parallel test operation. In test mode, three address bits pick one of eight sectors. Those three bits are the top row bit, the top column bit and the lowest column bit. A write fills the addressed cell in all eight sectors at once. A read folds the eight bits into one pass/fail bit, so a test pattern covers the array in one eighth of the accesses. Refresh is reported as a one-clock strobe with the row being refreshed. A driver or a checker can observe it there.

Top module: `dram_test_decoder`

## Requirements
- R1: After reset, `dout_en`, `test_mode` and `rfsh_stb` are 0 and `cyc_kind` is 0 (idle). All cells hold 0 and the refresh row counter holds 0.
- R2: A row strobe fall with the column strobe high latches `addr` as the row. A later column strobe fall with `we_n` high is a read. One clock after that fall is sampled, `dout_en` is 1, `dout` holds cell {row, col} and `cyc_kind` is 1.
- R3: If `we_n` is low when the column strobe fall is sampled, the access is an early write. `din` is stored at {row, col}, `dout_en` stays 0 and `cyc_kind` is 2.
- R4: If `we_n` falls while a read access is open, the access is a read-modify-write. `din` is stored at the read address, `dout` keeps the old data and `cyc_kind` is 3.
- R5: `dout_en` goes to 0 one clock after the column strobe rise is sampled. It stays 1, with unchanged data, while the column strobe is held low across a row strobe rise and fall.
- R6: A row strobe fall while the column strobe is already low is a counter refresh. `rfsh_stb` pulses for one clock with `rfsh_row` equal to the counter, and `addr` is ignored. The counter then steps by one modulo 2^ADDR_W. No cell changes, and `cyc_kind` is 4.
- R7: A row strobe low period with no column strobe fall is an explicit-row refresh. When the rise is sampled, `rfsh_stb` pulses with `rfsh_row` equal to the latched row. `test_mode` clears and `cyc_kind` is 5.
- R8: A counter refresh with `we_n` low at the row strobe fall sets `test_mode`, or keeps it set. It still refreshes from the counter, and `cyc_kind` is 6.
- R9: A counter refresh with `we_n` high at the row strobe fall clears `test_mode`.
- R10: In test mode a write stores `din` in all eight cells that differ only in row bit ADDR_W-1, column bit ADDR_W-1 and column bit 0. Those three address bits have no effect.
- R11: In a test-mode read, `dout` is 1 if the eight sector bits are all equal and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data or test-mode pass bit |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |
| test_mode | output | 1 | 1 while in parallel test mode |
| rfsh_stb | output | 1 | One-clock refresh pulse |
| rfsh_row | output | ADDR_W | Row refreshed by the current pulse |
| cyc_kind | output | 3 | Class of the latest cycle (0 idle, 1 read, 2 early write, 3 RMW, 4 counter refresh, 5 explicit refresh, 6 test entry) |

## Verification
A wrong mode flag shows on the next read. A test-mode read returns a compare bit where a cell value was expected, and normal-mode reads after a test write show a single cell where eight were filled. A refresh counter that skips or fails to wrap gives a wrong `rfsh_row` on the very next counter refresh. A lost open-row or access flag shows within one cycle as a missing or spurious `rfsh_stb` at the row strobe rise, or as `dout_en` held on after the column strobe rises. Random cycle mixes against a bench model of cells, counter and mode expose these within a few accesses.

// File: rtl/dram_cyc_pkg.sv
// Shared cycle classification for the DRAM cycle decoder.
package dram_cyc_pkg;
    typedef enum logic [2:0] {
        CK_IDLE     = 3'd0,
        CK_READ     = 3'd1,
        CK_EWRITE   = 3'd2,
        CK_RMW      = 3'd3,
        CK_CTR_RF   = 3'd4,
        CK_ROW_RF   = 3'd5,
        CK_TEST_IN  = 3'd6
    } cyc_kind_t;
endpackage

// File: rtl/dram_strobe_edges.sv
// Edge detector for the three active-low control strobes.
// Assumes the strobes are already synchronous to clk; reset treats all as idle (high).
module dram_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic cas_rise,
    output logic we_fall
);
    logic ras_q, cas_q, we_q;

    // Hold last sampled strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    // Compare current level with the previous sample.
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = ~ras_q & ras_n;
        cas_fall = cas_q & ~cas_n;
        cas_rise = ~cas_q & cas_n;
        we_fall  = we_q & ~we_n;
    end
endmodule

// File: rtl/dram_cell_array.sv
// Register array standing in for the DRAM cells, indexed {row, col}.
// In test mode the sector bits (row MSB, col MSB, col LSB) are replaced by all
// eight combinations: writes fill all eight, reads return an all-equal flag.
// Assumes ADDR_W >= 3.
module dram_cell_array #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic              rd_bit
);
    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam int NSECT = 8;

    logic             mem [DEPTH];
    logic [IDX_W-1:0] sect_idx [NSECT];
    logic [NSECT-1:0] sect_bits;
    logic [IDX_W-1:0] norm_idx;

    assign norm_idx = {row, col};

    // One index and one read tap per sector.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        localparam logic [2:0] SEL = 3'(s);
        assign sect_idx[s]  = {SEL[2], row[ADDR_W-2:0], SEL[1], col[ADDR_W-2:1], SEL[0]};
        assign sect_bits[s] = mem[sect_idx[s]];
    end

    // Single-cell read in normal mode, all-equal compare in test mode.
    assign rd_bit = test_mode ? ((&sect_bits) | ~(|sect_bits)) : mem[norm_idx];

    // Clear on reset; write one cell or all eight sector cells.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
        end else if (wr_en) begin
            if (test_mode) begin
                for (int k = 0; k < NSECT; k++) mem[sect_idx[k]] <= wr_bit;
            end else begin
                mem[norm_idx] <= wr_bit;
            end
        end
    end
endmodule

// File: rtl/dram_cycle_ctl.sv
// Cycle classifier: latches row/column, decides access kind, runs the refresh
// row counter and the test-mode flag, and owns the output data register.
// Assumes strobe edge flags come from dram_strobe_edges on the same clock.
module dram_cycle_ctl
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              we_fall,
    input  logic              rd_bit,
    output logic [ADDR_W-1:0] acc_row,
    output logic [ADDR_W-1:0] acc_col,
    output logic              wr_en,
    output logic              dout,
    output logic              dout_en,
    output logic              test_mode,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row,
    output cyc_kind_t         kind
);
    logic [ADDR_W-1:0] row_q, col_q, rf_cnt;
    logic row_open, cas_seen, rd_active;
    logic start_acc, rmw_hit;

    // Access start and write-strobe decode.
    always_comb begin
        start_acc = cas_fall & row_open;
        rmw_hit   = we_fall & rd_active & ~cas_n;
        wr_en     = (start_acc & ~we_n) | rmw_hit;
        acc_row   = row_q;
        acc_col   = start_acc ? addr : col_q;
    end

    // Cycle state, refresh counter, mode flag and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            col_q     <= '0;
            rf_cnt    <= '0;
            row_open  <= 1'b0;
            cas_seen  <= 1'b0;
            rd_active <= 1'b0;
            dout      <= 1'b0;
            dout_en   <= 1'b0;
            test_mode <= 1'b0;
            rfsh_stb  <= 1'b0;
            rfsh_row  <= '0;
            kind      <= CK_IDLE;
        end else begin
            rfsh_stb <= 1'b0;
            if (ras_fall) begin
                if (!cas_n) begin
                    rfsh_stb  <= 1'b1;
                    rfsh_row  <= rf_cnt;
                    rf_cnt    <= rf_cnt + ADDR_W'(1);
                    test_mode <= ~we_n;
                    kind      <= we_n ? CK_CTR_RF : CK_TEST_IN;
                end else begin
                    row_q    <= addr;
                    row_open <= 1'b1;
                    cas_seen <= 1'b0;
                end
            end
            if (ras_rise) begin
                row_open <= 1'b0;
                if (row_open && !cas_seen) begin
                    rfsh_stb  <= 1'b1;
                    rfsh_row  <= row_q;
                    test_mode <= 1'b0;
                    kind      <= CK_ROW_RF;
                end
            end
            if (start_acc) begin
                col_q    <= addr;
                cas_seen <= 1'b1;
                if (!we_n) begin
                    kind      <= CK_EWRITE;
                    dout_en   <= 1'b0;
                    rd_active <= 1'b0;
                end else begin
                    kind      <= CK_READ;
                    dout      <= rd_bit;
                    dout_en   <= 1'b1;
                    rd_active <= 1'b1;
                end
            end
            if (rmw_hit) begin
                kind      <= CK_RMW;
                rd_active <= 1'b0;
            end
            if (cas_rise) begin
                dout_en   <= 1'b0;
                rd_active <= 1'b0;
            end
        end
    end

    a_r8_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !cas_n && !we_n) |=> test_mode);

    a_r9_plain_cbr_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !cas_n && we_n) |=> !test_mode);

    a_r6_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !cas_n) |=> (rf_cnt == $past(rf_cnt) + ADDR_W'(1)));

    a_r3_early_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && row_open && !we_n) |=> !dout_en);

    a_r7_row_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_rise && row_open && !cas_seen) |=> (rfsh_stb && rfsh_row == $past(row_q) && !test_mode));

    a_r5_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cas_rise |=> !dout_en);
endmodule

// File: rtl/dram_test_decoder.sv
// Top: DRAM cycle decoder with parallel test mode.
// Samples active-low strobes on clk; strobes are assumed synchronous and glitch-free.
module dram_test_decoder
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_en,
    output logic              test_mode,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic [2:0]        cyc_kind
);
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [ADDR_W-1:0] acc_row, acc_col;
    logic wr_en, rd_bit;
    cyc_kind_t kind;

    dram_strobe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
        .cas_rise(cas_rise), .we_fall(we_fall)
    );

    dram_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
        .cas_rise(cas_rise), .we_fall(we_fall), .rd_bit(rd_bit),
        .acc_row(acc_row), .acc_col(acc_col), .wr_en(wr_en),
        .dout(dout), .dout_en(dout_en), .test_mode(test_mode),
        .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .kind(kind)
    );

    dram_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .row(acc_row),
        .col(acc_col), .wr_en(wr_en), .wr_bit(din), .rd_bit(rd_bit)
    );

    assign cyc_kind = kind;
endmodule

// File: tb/sim_dram_test_decoder.sv
module sim_dram_test_decoder;
    localparam int AW = 4;
    localparam int NC = 1 << (2 * AW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic dout, dout_en, test_mode, rfsh_stb;
    logic [AW-1:0] rfsh_row;
    logic [2:0] cyc_kind;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    bit mem_m [NC];
    bit tm_m = 1'b0;
    int cnt_m = 0;

    always #10 clk = ~clk;

    dram_test_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .test_mode(test_mode), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row),
        .cyc_kind(cyc_kind)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sidx(int r, int c, int s);
        int rr = (r & ((1 << (AW-1)) - 1)) | (((s >> 2) & 1) << (AW-1));
        int cc = (c & ((1 << (AW-1)) - 2)) | (((s >> 1) & 1) << (AW-1)) | (s & 1);
        return (rr << AW) | cc;
    endfunction

    function automatic int exp_read(int r, int c);
        int ones = 0;
        if (!tm_m) return int'(mem_m[(r << AW) | c]);
        for (int s = 0; s < 8; s++) ones += int'(mem_m[sidx(r, c, s)]);
        return (ones == 0 || ones == 8) ? 1 : 0;
    endfunction

    function automatic void model_write(int r, int c, bit d);
        if (tm_m) for (int s = 0; s < 8; s++) mem_m[sidx(r, c, s)] = d;
        else mem_m[(r << AW) | c] = d;
    endfunction

    task automatic idle_release();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    // Read, optionally turned into read-modify-write (R2, R4, R5, R11).
    task automatic do_read(int r, int c, bit rmw, bit d);
        int e;
        @(negedge clk); addr = AW'(r); ras_n = 1'b0;
        @(negedge clk); addr = AW'(c); cas_n = 1'b0;
        e = exp_read(r, c);
        @(negedge clk);
        check(tm_m ? "R11 test read" : "R2 read data", int'(dout), e);
        check("R2 oe on", int'(dout_en), 1);
        check("R2 kind", int'(cyc_kind), 1);
        if (rmw) begin
            we_n = 1'b0; din = d;
            @(negedge clk);
            check("R4 rmw old data", int'(dout), e);
            check("R4 kind", int'(cyc_kind), 3);
            model_write(r, c, d);
        end
        idle_release();
        @(negedge clk);
        check("R5 oe off", int'(dout_en), 0);
    endtask

    // Early write (R3, R10).
    task automatic do_write(int r, int c, bit d);
        @(negedge clk); addr = AW'(r); ras_n = 1'b0;
        @(negedge clk); addr = AW'(c); we_n = 1'b0; din = d; cas_n = 1'b0;
        @(negedge clk);
        check("R3 oe stays off", int'(dout_en), 0);
        check("R3 kind", int'(cyc_kind), 2);
        model_write(r, c, d);
        idle_release();
        @(negedge clk);
    endtask

    // Counter refresh, with write low for test entry (R6, R8, R9).
    task automatic do_cbr(bit wlow);
        @(negedge clk); cas_n = 1'b0; we_n = ~wlow; addr = AW'($urandom);
        @(negedge clk); ras_n = 1'b0; addr = AW'($urandom);
        @(negedge clk);
        check("R6 refresh pulse", int'(rfsh_stb), 1);
        check("R6 counter row", int'(rfsh_row), cnt_m);
        check(wlow ? "R8 kind" : "R6 kind", int'(cyc_kind), wlow ? 6 : 4);
        check(wlow ? "R8 enter test" : "R9 leave test", int'(test_mode), int'(wlow));
        cnt_m = (cnt_m + 1) % (1 << AW);
        tm_m = wlow;
        idle_release();
        @(negedge clk);
        check("R6 pulse width", int'(rfsh_stb), 0);
    endtask

    // Explicit-row refresh (R7).
    task automatic do_rowrf(int r);
        @(negedge clk); addr = AW'(r); ras_n = 1'b0;
        @(negedge clk); addr = AW'($urandom);
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk);
        check("R7 refresh pulse", int'(rfsh_stb), 1);
        check("R7 row", int'(rfsh_row), r);
        check("R7 kind", int'(cyc_kind), 5);
        check("R7 leave test", int'(test_mode), 0);
        tm_m = 1'b0;
    endtask

    // Read held across a counter refresh (R5, R6).
    task automatic do_hidden(int r, int c);
        int e;
        @(negedge clk); addr = AW'(r); ras_n = 1'b0;
        @(negedge clk); addr = AW'(c); cas_n = 1'b0;
        e = exp_read(r, c);
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk); ras_n = 1'b0;
        @(negedge clk);
        check("R5 hidden oe", int'(dout_en), 1);
        check("R5 hidden data", int'(dout), e);
        check("R6 hidden pulse", int'(rfsh_stb), 1);
        check("R6 hidden row", int'(rfsh_row), cnt_m);
        cnt_m = (cnt_m + 1) % (1 << AW);
        tm_m = 1'b0;
        idle_release();
        @(negedge clk);
        check("R5 hidden oe off", int'(dout_en), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NC; i++) mem_m[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", int'(dout_en), 0);
        check("R1 mode", int'(test_mode), 0);
        check("R1 pulse", int'(rfsh_stb), 0);
        check("R1 kind", int'(cyc_kind), 0);
        do_read(5, 9, 1'b0, 1'b0);
        do_cbr(1'b0);

        // Normal write then read back; read-modify-write.
        do_write(3, 7, 1'b1);
        do_read(3, 7, 1'b0, 1'b0);
        do_read(3, 7, 1'b1, 1'b0);
        do_read(3, 7, 1'b0, 1'b0);

        // R10: test write fills eight sectors, seen cell by cell in normal mode.
        do_cbr(1'b1);
        do_cbr(1'b1);
        do_write(2, 6, 1'b1);
        do_read(10, 15, 1'b0, 1'b0);
        do_cbr(1'b0);
        for (int s = 0; s < 8; s++) do_read(sidx(2, 6, s) >> AW, sidx(2, 6, s) % (1 << AW), 1'b0, 1'b0);

        // R11: break one sector, then a test read fails.
        do_write(sidx(2, 6, 5) >> AW, sidx(2, 6, 5) % (1 << AW), 1'b0);
        do_cbr(1'b1);
        do_read(2, 6, 1'b0, 1'b0);
        do_rowrf(9);
        do_hidden(3, 7);

        // Counter wrap.
        for (int k = 0; k < 18; k++) do_cbr(1'b0);

        // Random cycle mix.
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            int r = int'($urandom_range(0, (1 << AW) - 1));
            int c = int'($urandom_range(0, (1 << AW) - 1));
            bit d = 1'($urandom);
            case (op)
                0, 1, 2: do_write(r, c, d);
                3, 4:    do_read(r, c, 1'b0, 1'b0);
                5:       do_read(r, c, 1'b1, d);
                6:       do_cbr(1'b1);
                7:       do_cbr(1'b0);
                8:       do_rowrf(r);
                default: do_hidden(r, c);
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule